// File: doc/BRIEF.md
# PWM Fault Input Conditioner

This block prepares an external fault or retrigger pin for a PWM output stage. The raw pin is asynchronous to the PWM module clock, so it is first brought into the clock domain. It can then pass through an optional glitch filter, which only accepts a new level after that level has been steady for a fixed number of clocks. The accepted level is compared against a selectable active polarity. In edge mode it produces a one-clock event pulse for the PWM state logic. In level mode it holds every PWM output inactive for as long as the input stays active, which gives a burst pattern.

A separate combinational kill path can be enabled. It forces the outputs inactive straight from the raw pin, so the outputs are cut even when the module clock is stopped or disturbed. The clocked path keeps evaluating the same pin whenever the clock runs. The PWM counter and waveform generator are outside this block. Four incoming PWM bits stand in for them and are gated at the output.

Top module: `pwm_fault_cond`

## Requirements
- R1: While `rst` is high and on the first clock after it, the accepted level holds the inactive polarity, the filter count is zero, `event_o` is 0, and `pwm_o` equals `pwm_i` when the asynchronous path is off.
- R2: With `filt_en_i`=1, a new synchronized level is accepted only after it has been seen on 4 consecutive clock edges. A pin level that lasts 3 clocks or less is ignored and produces no kill and no event.
- R3: With `filt_en_i`=0, the filter is bypassed and the accepted level follows the synchronized level on every clock. A pin change reaches `kill_o` on the third rising edge after it.
- R4: The raw pin crosses a two-flop synchronizer. With the filter enabled, a steady pin change reaches `kill_o` on the sixth rising edge after it.
- R5: `act_high_i`=1 makes a high level active and `act_high_i`=0 makes a low level active. The polarity is changed only while `rst` is high.
- R6: With `edge_mode_i`=1, `event_o` is high for exactly one clock, one clock after the accepted level becomes active. In this mode the clocked path never asserts `kill_o`.
- R7: With `edge_mode_i`=0, `kill_o` is high while the accepted level is active and `event_o` stays 0.
- R8: With `async_en_i`=1, an active raw pin level drives `kill_o` high and `pwm_o` to zero with no clock edge needed.
- R9: With `async_en_i`=1, the clocked path still evaluates the pin once the clock runs, so in edge mode `event_o` still pulses.
- R10: Each `pwm_o` bit equals the matching `pwm_i` bit ANDed with NOT `kill_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM module clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_pin_i | input | 1 | Raw asynchronous fault/retrigger pin |
| filt_en_i | input | 1 | 1 enables the 4-clock glitch filter |
| edge_mode_i | input | 1 | 1 selects edge mode, 0 selects level mode |
| act_high_i | input | 1 | 1 means a high level is active, 0 means a low level is active |
| async_en_i | input | 1 | 1 enables the clockless kill path |
| pwm_i | input | 4 | Incoming PWM output bits |
| pwm_o | output | 4 | Gated PWM output bits |
| event_o | output | 1 | One-clock event pulse (edge mode) |
| kill_o | output | 1 | Combined kill (clocked level kill OR async kill) |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a filter length of 4 and four PWM bits. With these values the latencies of 3 and 6 edges, and the 3-clock glitch that must be ignored, can be checked by hand against a behavioural model. That model is compared on every clock. Stopping the bench clock brings the clockless kill path within reach, and two resets bring both polarities within reach.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  // Level is active when it matches the selected polarity.
  function automatic logic lvl_is_active(input logic lvl, input logic act_high);
    return lvl == act_high;
  endfunction

  // Next filter count: count up while the sample disagrees with the accepted level.
  function automatic int unsigned filt_count_next(input logic differs, input int unsigned cnt);
    return differs ? cnt + 1 : 0;
  endfunction
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{rst_val}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pfc_filter.sv
module pfc_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic en,
  input  logic d,
  output logic acc_o,
  output logic upd_o
);
  import pfc_pkg::*;
  localparam int CNT_W = $clog2(LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic             acc;
  logic             differs;
  logic             full;

  assign differs = (d != acc);
  assign full    = en && differs && (cnt == CNT_W'(LEN - 1));
  assign upd_o   = full || (!en && differs);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= rst_val;
      cnt <= '0;
    end else if (!en) begin
      acc <= d;
      cnt <= '0;
    end else if (full) begin
      acc <= d;
      cnt <= '0;
    end else begin
      cnt <= CNT_W'(filt_count_next(differs, int'(cnt)));
    end
  end

  assign acc_o = acc;

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(LEN));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (en && cnt != CNT_W'(LEN - 1)) |=> $stable(acc));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc == $past(d)));
endmodule

// File: rtl/pfc_detect.sv
module pfc_detect (
  input  logic clk,
  input  logic rst,
  input  logic edge_mode,
  input  logic active,
  output logic event_o,
  output logic lvl_kill_o
);
  logic prev_act;
  logic evt_q;
  logic rise;

  assign rise = active && !prev_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_act <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      prev_act <= active;
      evt_q    <= edge_mode && rise;
    end
  end

  assign event_o    = evt_q;
  assign lvl_kill_o = !edge_mode && active;

  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o);
  assert_level_noevt_R7: assert property (@(posedge clk) disable iff (rst)
    !edge_mode |=> !event_o);
  assert_edge_nokill_R6: assert property (@(posedge clk) disable iff (rst)
    edge_mode |-> !lvl_kill_o);
endmodule

// File: rtl/pwm_fault_cond.sv
module pwm_fault_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int NUM_OUT     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fault_pin_i,
  input  logic               filt_en_i,
  input  logic               edge_mode_i,
  input  logic               act_high_i,
  input  logic               async_en_i,
  input  logic [NUM_OUT-1:0] pwm_i,
  output logic [NUM_OUT-1:0] pwm_o,
  output logic               event_o,
  output logic               kill_o
);
  import pfc_pkg::*;

  logic inact_lvl;
  logic sync_lvl;
  logic acc_lvl;
  logic acc_upd;
  logic acc_active;
  logic lvl_kill;
  logic async_kill;

  assign inact_lvl = !act_high_i;

  pfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rst_val(inact_lvl), .d(fault_pin_i), .q(sync_lvl)
  );

  pfc_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .rst_val(inact_lvl), .en(filt_en_i), .d(sync_lvl),
    .acc_o(acc_lvl), .upd_o(acc_upd)
  );

  assign acc_active = lvl_is_active(acc_lvl, act_high_i);

  pfc_detect u_det (
    .clk(clk), .rst(rst), .edge_mode(edge_mode_i), .active(acc_active),
    .event_o(event_o), .lvl_kill_o(lvl_kill)
  );

  assign async_kill = async_en_i && lvl_is_active(fault_pin_i, act_high_i);
  assign kill_o     = lvl_kill || async_kill;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    assign pwm_o[g] = pwm_i[g] && !kill_o;
  end

  assert_async_R8: assert property (@(posedge clk) disable iff (rst)
    (async_en_i && fault_pin_i == act_high_i) |-> (pwm_o == '0));
  assert_gate_R10: assert property (@(posedge clk) disable iff (rst)
    ((pwm_o & ~pwm_i) == '0));
  assert_upd_flip_R2: assert property (@(posedge clk) disable iff (rst)
    acc_upd |=> (acc_lvl != $past(acc_lvl)));
endmodule

// File: tb/pwm_fault_cond_tb_top.sv
module pwm_fault_cond_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst, pin, fe, edge_m, ah, aen;
  logic [3:0] pwm_i, pwm_o;
  logic event_o, kill_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) if (clk_run) clk = ~clk;

  pwm_fault_cond dut_i (
    .clk(clk), .rst(rst), .fault_pin_i(pin), .filt_en_i(fe), .edge_mode_i(edge_m),
    .act_high_i(ah), .async_en_i(aen), .pwm_i(pwm_i), .pwm_o(pwm_o),
    .event_o(event_o), .kill_o(kill_o)
  );

  // Behavioural reference
  logic ms1, ms2, macc, mprev, mevt, act_old;
  int   mrun;
  always @(posedge clk) begin
    if (rst) begin
      ms1 = ~ah; ms2 = ~ah; macc = ~ah; mrun = 0; mprev = 0; mevt = 0;
    end else begin
      act_old = (macc == ah);
      mevt  = edge_m && act_old && !mprev;
      mprev = act_old;
      if (!fe) begin
        macc = ms2; mrun = 0;
      end else if (ms2 != macc) begin
        mrun = mrun + 1;
        if (mrun == 4) begin macc = ms2; mrun = 0; end
      end else mrun = 0;
      ms2 = ms1; ms1 = pin;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison
  logic exp_kill;
  always @(negedge clk) begin
    pwm_i = pwm_i + 4'd3;
    #1;
    if (!rst) begin
      exp_kill = (!edge_m && macc == ah) || (aen && pin == ah);
      chk("R7", "kill_o", int'(kill_o), int'(exp_kill));
      chk("R6", "event_o", int'(event_o), int'(mevt));
      chk("R10", "pwm_o", int'(pwm_o), int'(pwm_i & {4{~exp_kill}}));
    end
  end

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst = 1'b1; ah = pol; pin = ~pol;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive pin active, count rising edges until kill_o seen.
  task automatic latency(input int exp, input string req);
    int cnt;
    cnt = 0;
    @(negedge clk);
    pin = ah;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      #2;
      if (kill_o) break;
    end
    chk(req, "latency", cnt, exp);
    pin = ~ah;
    idle(12);
  endtask

  int evcnt;
  int killseen;
  initial begin
    rst = 1'b1; pin = 1'b0; fe = 1'b1; edge_m = 1'b0; ah = 1'b1; aen = 1'b0; pwm_i = 4'h0;
    do_reset(1'b1);
    @(posedge clk); @(negedge clk); #2;
    chk("R1", "event_o after reset", int'(event_o), 0);
    chk("R1", "kill_o after reset", int'(kill_o), 0);
    chk("R1", "pwm pass after reset", int'(pwm_o), int'(pwm_i));

    // R2: 3-clock glitch ignored
    pin = 1'b1; idle(3); pin = 1'b0;
    killseen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); #2; if (kill_o) killseen = 1; end
    chk("R2", "glitch kill", killseen, 0);

    latency(6, "R4");
    fe = 1'b0;
    latency(3, "R3");
    fe = 1'b1;

    // R7 burst: level held then released
    @(negedge clk); pin = 1'b1; idle(10); #2;
    chk("R7", "level kill held", int'(kill_o), 1);
    chk("R7", "level pwm zero", int'(pwm_o), 0);
    pin = 1'b0; idle(10); #2;
    chk("R7", "level kill released", int'(kill_o), 0);

    // R6 edge mode
    edge_m = 1'b1; idle(2);
    evcnt = 0; killseen = 0;
    pin = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #2;
      if (event_o) evcnt++;
      if (kill_o) killseen = 1;
    end
    chk("R6", "event count", evcnt, 1);
    chk("R6", "edge kill", killseen, 0);
    pin = 1'b0; idle(10);

    // R5 low polarity, level mode
    edge_m = 1'b0;
    do_reset(1'b0);
    idle(8); #2;
    chk("R5", "idle high no kill", int'(kill_o), 0);
    latency(6, "R5");

    // R8 async kill with clock stopped, R9 clocked path afterwards
    aen = 1'b1; edge_m = 1'b1;
    do_reset(1'b1);
    idle(8);
    #(CLK_PERIOD/4);
    clk_run = 1'b0;
    #(CLK_PERIOD*3);
    pin = 1'b1; pwm_i = 4'hF;
    #1;
    chk("R8", "async kill stopped clk", int'(kill_o), 1);
    chk("R8", "async pwm zero", int'(pwm_o), 0);
    #(CLK_PERIOD*3);
    clk_run = 1'b1;
    evcnt = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); #2; if (event_o) evcnt++; end
    chk("R9", "event after async", evcnt, 1);
    pin = 1'b0; idle(2); #2;
    chk("R8", "async release", int'(kill_o), 0);
    idle(5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule